// File: doc/BRIEF.md
# Eight-Entry Fully Associative Translation Cache

This block keeps the most recent virtual-to-real page translations, so that an address which hits skips the page table walk. Every virtual address is offered to the cache first. All eight entries are compared at the same time. In the same cycle, the block reports a hit and drives the full real address. On a miss, an external table walker resolves the translation and writes it in through the fill port. A purge input empties the cache.

The page-size mode selects one of two field splits. With 2K pages the tag is 13 bits wide and the frame number is 13 bits wide. With 4K pages the tag and the frame number are 12 bits each. The cache must be purged whenever the mode changes. On a fill, the cache picks the slot to write in this order: an entry that already holds the same tag, then the lowest free entry, then a round-robin victim.

Top module: `xlate_cache`

## Requirements
- R1: After reset every entry is empty, so any lookup gives `lk_hit_o`=0 and `lk_ra_o`=0.
- R2: Lookup is combinational: `lk_hit_o` and `lk_ra_o` reflect `lk_va_i` in the same cycle, and `lk_ra_o` is all zeros on a miss.
- R3: With `pg4k_i`=0 the tag is `va[23:11]`, and a hit returns `{frame[12:0], va[10:0]}`.
- R4: With `pg4k_i`=1 the tag is `va[23:12]`, and a hit returns `{frame[11:0], va[11:0]}`. Frame bit 12 is ignored.
- R5: A fill is visible from the next cycle on. A lookup in the same cycle as the fill sees the old contents.
- R6: A fill whose tag matches no valid entry goes to the lowest-index invalid entry.
- R7: When all eight entries are valid, a 3-bit round-robin pointer selects the victim and then advances. The pointer is 0 after reset, moves only on such an eviction, and a purge does not move it.
- R8: A fill whose tag matches a valid entry overwrites that entry. No two valid entries ever hold the same tag.
- R9: A purge invalidates all entries in one cycle. A fill in the same cycle as a purge is dropped.
- R10: Eight distinct tags can be resident at once, and all of them hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg4k_i | input | 1 | Page-size mode: 0 selects 2K pages, 1 selects 4K pages |
| lk_va_i | input | 24 | Lookup virtual address |
| lk_hit_o | output | 1 | Lookup hit |
| lk_ra_o | output | 24 | Real address on a hit, zero on a miss |
| fill_en_i | input | 1 | Write one translation |
| fill_va_i | input | 24 | Virtual address of the translation being written |
| fill_frame_i | input | 13 | Frame number, right-justified; only bits [11:0] are used in 4K mode |
| purge_i | input | 1 | Invalidate all entries |

## Verification
The bench covers the following corner cases:
- **Same-cycle lookup and fill.** The bench looks up an address in the cycle it is being filled. A cache that forwarded fill data would report an early hit.
- **Refill of a resident tag.** The bench writes a tag that is already present with a new frame. A design that ignored the existing match would leave a stale duplicate, or would spend a free slot and evict the wrong page later.
- **Replacement after a purge.** The bench runs round-robin evictions before and after a purge. A pointer that reset on purge, or advanced on ordinary fills, would evict a different page, and a later lookup would miss where a hit is expected.
- **Fields and modes.** The bench checks the fill that arrives together with a purge, the frame bit 12 that 4K mode must ignore, and addresses that differ only in bit 11. Each exposes a dropped or mis-sized field.

// File: rtl/xlc_pkg.sv
package xlc_pkg;
  localparam int unsigned XLC_ENTRIES = 8;
  localparam int unsigned XLC_AW      = 24;
  localparam int unsigned XLC_MIN_OFF = 11;

  typedef enum logic {
    PG_2K = 1'b0,
    PG_4K = 1'b1
  } pg_mode_e;
endpackage

// File: rtl/xlc_entry.sv
module xlc_entry #(
  parameter int unsigned TAG_W = 13,
  parameter int unsigned FRM_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             purge_i,
  input  logic             wr_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [FRM_W-1:0] wr_frm_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  input  logic [TAG_W-1:0] fl_tag_i,
  output logic             vld_o,
  output logic             lk_hit_o,
  output logic             fl_hit_o,
  output logic [FRM_W-1:0] frm_o
);
  logic             vld_q, vld_d;
  logic             data_en;
  logic [TAG_W-1:0] tag_q;
  logic [FRM_W-1:0] frm_q;

  always_comb begin
    vld_d   = vld_q;
    data_en = wr_i & ~purge_i;
    if (purge_i)    vld_d = 1'b0;
    else if (wr_i)  vld_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      tag_q <= wr_tag_i;
      frm_q <= wr_frm_i;
    end
  end

  assign vld_o    = vld_q;
  assign lk_hit_o = vld_q && (tag_q == lk_tag_i);
  assign fl_hit_o = vld_q && (tag_q == fl_tag_i);
  assign frm_o    = frm_q;
endmodule

// File: rtl/xlc_victim.sv
module xlc_victim #(
  parameter int unsigned N_ENT = 8,
  localparam int unsigned PTR_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en_i,
  input  logic             purge_i,
  input  logic [N_ENT-1:0] vld_i,
  input  logic [N_ENT-1:0] fl_hit_i,
  output logic [N_ENT-1:0] wr_sel_o
);
  logic [PTR_W-1:0] rr_q, rr_d;
  logic [N_ENT-1:0] free_sel;
  logic             rr_adv;

  always_comb begin
    free_sel = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (!vld_i[i]) begin
        free_sel    = '0;
        free_sel[i] = 1'b1;
      end
    end
  end

  always_comb begin
    wr_sel_o = '0;
    rr_adv   = 1'b0;
    if (fill_en_i && !purge_i) begin
      if (|fl_hit_i)       wr_sel_o = fl_hit_i;
      else if (|free_sel)  wr_sel_o = free_sel;
      else begin
        wr_sel_o[rr_q] = 1'b1;
        rr_adv         = 1'b1;
      end
    end
  end

  always_comb begin
    rr_d = rr_q;
    if (rr_adv) rr_d = (rr_q == PTR_W'(N_ENT - 1)) ? '0 : rr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
  import xlc_pkg::*;
#(
  parameter int unsigned N_ENT   = XLC_ENTRIES,
  parameter int unsigned AW      = XLC_AW,
  parameter int unsigned MIN_OFF = XLC_MIN_OFF,
  localparam int unsigned TAG_W  = AW - MIN_OFF,
  localparam int unsigned FRM_W  = AW - MIN_OFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pg4k_i,
  input  logic [AW-1:0]    lk_va_i,
  output logic             lk_hit_o,
  output logic [AW-1:0]    lk_ra_o,
  input  logic             fill_en_i,
  input  logic [AW-1:0]    fill_va_i,
  input  logic [FRM_W-1:0] fill_frame_i,
  input  logic             purge_i
);
  pg_mode_e         mode;
  logic [TAG_W-1:0] lk_tag, fl_tag;
  logic [N_ENT-1:0] vld_vec, lk_hit_vec, fl_hit_vec, wr_sel;
  logic [FRM_W-1:0] frm_arr [N_ENT];
  logic [FRM_W-1:0] lk_frm;

  assign mode = pg_mode_e'(pg4k_i);

  always_comb begin
    if (mode == PG_4K) begin
      lk_tag = {1'b0, lk_va_i[AW-1:MIN_OFF+1]};
      fl_tag = {1'b0, fill_va_i[AW-1:MIN_OFF+1]};
    end else begin
      lk_tag = lk_va_i[AW-1:MIN_OFF];
      fl_tag = fill_va_i[AW-1:MIN_OFF];
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    xlc_entry #(.TAG_W(TAG_W), .FRM_W(FRM_W)) u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .purge_i  (purge_i),
      .wr_i     (wr_sel[g]),
      .wr_tag_i (fl_tag),
      .wr_frm_i (fill_frame_i),
      .lk_tag_i (lk_tag),
      .fl_tag_i (fl_tag),
      .vld_o    (vld_vec[g]),
      .lk_hit_o (lk_hit_vec[g]),
      .fl_hit_o (fl_hit_vec[g]),
      .frm_o    (frm_arr[g])
    );
  end

  xlc_victim #(.N_ENT(N_ENT)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_en_i (fill_en_i),
    .purge_i   (purge_i),
    .vld_i     (vld_vec),
    .fl_hit_i  (fl_hit_vec),
    .wr_sel_o  (wr_sel)
  );

  always_comb begin
    lk_frm = '0;
    for (int i = 0; i < N_ENT; i++) lk_frm |= frm_arr[i] & {FRM_W{lk_hit_vec[i]}};
  end

  assign lk_hit_o = |lk_hit_vec;

  always_comb begin
    if (!lk_hit_o)           lk_ra_o = '0;
    else if (mode == PG_4K)  lk_ra_o = {lk_frm[FRM_W-2:0], lk_va_i[MIN_OFF:0]};
    else                     lk_ra_o = {lk_frm, lk_va_i[MIN_OFF-1:0]};
  end
endmodule

// File: rtl/xlc_chk.sv
module xlc_chk #(
  parameter int unsigned N_ENT   = 8,
  parameter int unsigned AW      = 24,
  parameter int unsigned MIN_OFF = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pg4k_i,
  input logic [AW-1:0]    lk_va_i,
  input logic             lk_hit_o,
  input logic [AW-1:0]    lk_ra_o,
  input logic             fill_en_i,
  input logic [AW-1:0]    fill_va_i,
  input logic             purge_i,
  input logic [N_ENT-1:0] lk_hit_vec
);
  logic [AW-MIN_OFF-1:0] c_lk_tag, c_fl_tag;
  assign c_lk_tag = pg4k_i ? {1'b0, lk_va_i[AW-1:MIN_OFF+1]}   : lk_va_i[AW-1:MIN_OFF];
  assign c_fl_tag = pg4k_i ? {1'b0, fill_va_i[AW-1:MIN_OFF+1]} : fill_va_i[AW-1:MIN_OFF];

  AST_MISS_RA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit_o |-> (lk_ra_o == '0)); // R2
  AST_OFFSET_2K: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit_o && !pg4k_i) |-> (lk_ra_o[MIN_OFF-1:0] == lk_va_i[MIN_OFF-1:0])); // R3
  AST_OFFSET_4K: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit_o && pg4k_i) |-> (lk_ra_o[MIN_OFF:0] == lk_va_i[MIN_OFF:0])); // R4
  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en_i && !purge_i) |=>
      (((pg4k_i == $past(pg4k_i)) && (c_lk_tag == $past(c_fl_tag))) -> lk_hit_o)); // R5
  AST_NO_DUP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit_vec)); // R8
  AST_PURGE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    purge_i |=> !lk_hit_o); // R9
endmodule

bind xlate_cache xlc_chk #(.N_ENT(N_ENT), .AW(AW), .MIN_OFF(MIN_OFF)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pg4k_i     (pg4k_i),
  .lk_va_i    (lk_va_i),
  .lk_hit_o   (lk_hit_o),
  .lk_ra_o    (lk_ra_o),
  .fill_en_i  (fill_en_i),
  .fill_va_i  (fill_va_i),
  .purge_i    (purge_i),
  .lk_hit_vec (lk_hit_vec)
);

// File: tb/xlate_cache_tb.sv
module xlate_cache_tb;
  logic        clk;
  logic        rst_n;
  logic        pg4k;
  logic [23:0] lk_va;
  logic        lk_hit;
  logic [23:0] lk_ra;
  logic        fill_en;
  logic [23:0] fill_va;
  logic [12:0] fill_frame;
  logic        purge;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  bit        m_vld [8];
  bit [12:0] m_tag [8];
  bit [12:0] m_frm [8];
  int        m_rr;
  bit [23:0] seen [$];

  xlate_cache u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .pg4k_i       (pg4k),
    .lk_va_i      (lk_va),
    .lk_hit_o     (lk_hit),
    .lk_ra_o      (lk_ra),
    .fill_en_i    (fill_en),
    .fill_va_i    (fill_va),
    .fill_frame_i (fill_frame),
    .purge_i      (purge)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit [12:0] tag_of(bit [23:0] va, bit pg);
    return pg ? {1'b0, va[23:12]} : va[23:11];
  endfunction

  function automatic bit [24:0] ref_lookup(bit [23:0] va, bit pg);
    for (int i = 0; i < 8; i++) begin
      if (m_vld[i] && m_tag[i] == tag_of(va, pg))
        return pg ? {1'b1, m_frm[i][11:0], va[11:0]} : {1'b1, m_frm[i], va[10:0]};
    end
    return 25'd0;
  endfunction

  task automatic ref_update();
    int slot = -1;
    if (purge) begin
      for (int i = 0; i < 8; i++) m_vld[i] = 0;
      return;
    end
    if (!fill_en) return;
    for (int i = 0; i < 8; i++)
      if (slot < 0 && m_vld[i] && m_tag[i] == tag_of(fill_va, pg4k)) slot = i;
    for (int i = 0; i < 8; i++)
      if (slot < 0 && !m_vld[i]) slot = i;
    if (slot < 0) begin
      slot = m_rr;
      m_rr = (m_rr + 1) % 8;
    end
    m_vld[slot] = 1;
    m_tag[slot] = tag_of(fill_va, pg4k);
    m_frm[slot] = fill_frame;
  endtask

  task automatic step(string req, bit fe, bit [23:0] fva, bit [12:0] ffr,
                      bit [23:0] lva, bit pu);
    bit [24:0] exp;
    fill_en = fe; fill_va = fva; fill_frame = ffr; lk_va = lva; purge = pu;
    #1;
    exp = ref_lookup(lva, pg4k);
    checks++;
    if ({lk_hit, lk_ra} !== exp) begin
      errors++;
      $display("FAIL %s va=%h actual hit=%0b ra=%h expected hit=%0b ra=%h",
               req, lva, lk_hit, lk_ra, exp[24], exp[23:0]);
    end
    @(posedge clk);
    ref_update();
    @(negedge clk);
  endtask

  task automatic probe_all(string req);
    foreach (seen[i]) begin
      step(req, 0, 24'h0, 13'h0, seen[i] ^ 24'h00_0155, 0);
    end
  endtask

  task automatic fill(string req, bit [23:0] va, bit [12:0] frm);
    step(req, 1, va, frm, va, 0);
    seen.push_back(va);
  endtask

  function automatic bit [23:0] va2k(int t, int off);
    return {t[12:0], off[10:0]};
  endfunction

  function automatic bit [23:0] va4k(int t, int off);
    return {t[11:0], off[11:0]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pg4k = 0; lk_va = '0; fill_en = 0; fill_va = '0;
    fill_frame = '0; purge = 0; m_rr = 0;
    for (int i = 0; i < 8; i++) m_vld[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: empty after reset
    step("R1", 0, 24'h0, 13'h0, va2k(1, 5), 0);
    step("R1", 0, 24'h0, 13'h0, 24'h00_0000, 0);

    // R6 / R5: fill eight distinct 2K pages, same-cycle lookup must still miss
    for (int k = 0; k < 8; k++) fill("R5", va2k(k + 1, 0), 13'h1000 + 13'(k));
    // R10 / R3: all eight resident, offsets pass through
    probe_all("R10");
    step("R3", 0, 24'h0, 13'h0, va2k(2, 11'h7ff), 0);
    step("R3", 0, 24'h0, 13'h0, va2k(9, 0), 0);

    // R8: refill a resident tag with a new frame
    fill("R8", va2k(3, 0), 13'h0abc);
    probe_all("R8");

    // R7: evictions by round robin
    for (int k = 0; k < 3; k++) fill("R7", va2k(20 + k, 0), 13'h0200 + 13'(k));
    probe_all("R7");

    // R9: purge wins over same-cycle fill
    step("R9", 1, va2k(30, 0), 13'h0333, va2k(1, 4), 1);
    seen.push_back(va2k(30, 0));
    probe_all("R9");

    // R7 / R6: pointer kept across purge
    for (int k = 0; k < 9; k++) fill("R7", va2k(40 + k, 0), 13'h0400 + 13'(k));
    probe_all("R7");
    step("R2", 0, 24'h0, 13'h0, va2k(99, 1), 0);

    // R4: 4K mode after a purge, frame bit 12 ignored
    step("R9", 0, 24'h0, 13'h0, va2k(40, 0), 1);
    pg4k = 1;
    seen.delete();
    for (int k = 0; k < 6; k++) fill("R4", va4k(k + 5, 0), 13'h1000 | 13'(k * 7));
    probe_all("R4");
    step("R4", 0, 24'h0, 13'h0, va4k(6, 12'h800), 0);
    step("R4", 0, 24'h0, 13'h0, va4k(6, 12'hfff), 0);
    step("R4", 0, 24'h0, 13'h0, va4k(11, 12'h001), 0);

    step("R9", 0, 24'h0, 13'h0, va4k(5, 0), 1);
    probe_all("R9");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule